// File: doc/BRIEF.md
# Three-Way LRU Age Tracker

This block keeps the replacement order for one set of a set-associative cache. Each way holds a small age counter. Age 0 means the way was used most recently, and the highest age marks the least-recently-used way. A cache builds one tracker per set. Each time a way in the set is hit or filled, the cache sends the tracker a single-cycle touch for that way. On a miss, the tracker's victim output names the way to replace.

Ages do not begin distinct. After reset every way reads age 0, and the tracker ignores touches until it has been primed. A prime pulse loads way i with age i, which turns the ages into a permutation. From then on every touch keeps them a permutation. The identity of a way is its index. Its age is a separate value that the tracker holds for it, and the victim output is always an index.

Top module: `lru_age_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every way's age becomes 0 and `ready` becomes 0; with all ages 0, `victim_way` reads 0.
- R2: A cycle with `init` high makes way i hold age i (field `way_ages[i*2 +: 2]`) and makes `ready` 1 from the next cycle on.
- R3: While `ready` is 0, a touch leaves every age unchanged.
- R4: When primed, a touch of way N gives way N age 0, adds one to each way whose age was below N's old age, and leaves older ways unchanged; the result shows one cycle after the touch.
- R5: Once `ready` is 1, the three ages are always a permutation of 0, 1 and 2.
- R6: `victim_way` is the index of the way whose age is 2, derived from the current ages with no added cycle of delay.
- R7: When `init` and a touch are both high in one cycle, the ages take the prime values and the touch is discarded.
- R8: A touch whose `touch_way` is 3, which is not a valid way, changes no age.
- R9: Touching the way that already has age 0 leaves every age unchanged.
- R10: An `init` pulse while already primed restores the order way 0 youngest, way 2 oldest, whatever the current order.
- R11: In a cycle with neither `init` nor a touch, the ages hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Prime pulse: loads way i with age i |
| touch_vld | input | 1 | A hit or fill on `touch_way` this cycle |
| touch_way | input | 2 | Index of the touched way |
| ready | output | 1 | High once the ages have been primed |
| victim_way | output | 2 | Index of the least-recently-used way |
| way_ages | output | 6 | Age of way i in bits [i*2 +: 2]; 0 is most recent |

## Verification
On every cycle, the bound checker confirms the following. The primed ages form a permutation. The victim points at the oldest way. A touched way reads age 0 one cycle after the touch. Cycles with no touch, with an invalid index, or before priming leave the ages alone, and a prime loads the identity order. The bench checks what a per-cycle property cannot: that the whole recency order matches a reference that moves the touched way to the front of a list. That covers which ways age and which stay put over long random mixes of touches, re-primes and idle cycles. Directed cases add a touch of the youngest way, an invalid index, prime and touch together, and a re-prime from a scrambled order.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
  // Bits needed to hold an index or an age for n ways (at least one).
  function automatic int unsigned field_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lru_age_way.sv
// Age register for one way, with its own update rule.
module lru_age_way #(
  parameter int unsigned AGE_W    = 2,
  parameter int unsigned INIT_AGE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             touch_i,
  input  logic             hit_i,
  input  logic [AGE_W-1:0] ref_age_i,
  output logic [AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] START = AGE_W'(INIT_AGE);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (load_i) begin
      age_q <= START;
    end else if (touch_i) begin
      if (hit_i) begin
        age_q <= '0;
      end else if (age_q < ref_age_i) begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  assign age_o = age_q;
endmodule

// File: rtl/lru_victim_enc.sv
// Finds the way that holds the oldest age.
module lru_victim_enc #(
  parameter int unsigned NUM_WAYS = 3,
  parameter int unsigned AGE_W    = 2,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [NUM_WAYS*AGE_W-1:0] ages_i,
  output logic [IDX_W-1:0]          victim_o
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(NUM_WAYS - 1);

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < int'(NUM_WAYS); i++) begin
      if (ages_i[i*AGE_W +: AGE_W] == OLDEST) begin
        victim_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker #(
  parameter int unsigned NUM_WAYS = 3,
  localparam int unsigned IDX_W = lru_age_pkg::field_width(NUM_WAYS),
  localparam int unsigned AGE_W = lru_age_pkg::field_width(NUM_WAYS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      init,
  input  logic                      touch_vld,
  input  logic [IDX_W-1:0]          touch_way,
  output logic                      ready,
  output logic [IDX_W-1:0]          victim_way,
  output logic [NUM_WAYS*AGE_W-1:0] way_ages
);
  logic             primed_q;
  logic             way_ok;
  logic             touch_en;
  logic [AGE_W-1:0] ref_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
    end else if (init) begin
      primed_q <= 1'b1;
    end
  end

  assign way_ok   = 32'(touch_way) < NUM_WAYS;
  assign touch_en = touch_vld && primed_q && way_ok;

  // Old age of the touched way.
  always_comb begin
    ref_age = '0;
    for (int i = 0; i < int'(NUM_WAYS); i++) begin
      if (touch_way == IDX_W'(i)) begin
        ref_age = way_ages[i*AGE_W +: AGE_W];
      end
    end
  end

  for (genvar g = 0; g < int'(NUM_WAYS); g++) begin : g_way
    lru_age_way #(
      .AGE_W   (AGE_W),
      .INIT_AGE(g)
    ) way_i (
      .clk      (clk),
      .rst      (rst),
      .load_i   (init),
      .touch_i  (touch_en),
      .hit_i    (touch_way == IDX_W'(g)),
      .ref_age_i(ref_age),
      .age_o    (way_ages[g*AGE_W +: AGE_W])
    );
  end

  lru_victim_enc #(
    .NUM_WAYS(NUM_WAYS),
    .AGE_W   (AGE_W),
    .IDX_W   (IDX_W)
  ) enc_i (
    .ages_i  (way_ages),
    .victim_o(victim_way)
  );

  assign ready = primed_q;
endmodule

// File: rtl/lru_age_chk.sv
module lru_age_chk #(
  parameter int unsigned NUM_WAYS = 3,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned AGE_W    = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      init,
  input logic                      touch_vld,
  input logic [IDX_W-1:0]          touch_way,
  input logic                      ready,
  input logic [IDX_W-1:0]          victim_way,
  input logic [NUM_WAYS*AGE_W-1:0] way_ages
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(NUM_WAYS - 1);

  logic [NUM_WAYS*AGE_W-1:0] ident;
  always_comb begin
    for (int i = 0; i < int'(NUM_WAYS); i++) begin
      ident[i*AGE_W +: AGE_W] = AGE_W'(i);
    end
  end

  for (genvar v = 0; v < int'(NUM_WAYS); v++) begin : g_val
    logic [NUM_WAYS-1:0] holds;
    always_comb begin
      for (int i = 0; i < int'(NUM_WAYS); i++) begin
        holds[i] = (way_ages[i*AGE_W +: AGE_W] == AGE_W'(v));
      end
    end
    p_age_unique_r5: assert property (@(posedge clk) disable iff (rst)
      ready |-> $countones(holds) == 1);
  end

  p_prime_load_r2: assert property (@(posedge clk) disable iff (rst)
    init |=> (ready && way_ages == ident));

  p_touch_youngest_r4: assert property (@(posedge clk) disable iff (rst)
    (touch_vld && ready && !init && 32'(touch_way) < NUM_WAYS)
      |=> way_ages[$past(touch_way)*AGE_W +: AGE_W] == '0);

  p_victim_oldest_r6: assert property (@(posedge clk) disable iff (rst)
    ready |-> way_ages[victim_way*AGE_W +: AGE_W] == OLDEST);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!init && !touch_vld) |=> $stable(way_ages));

  p_unprimed_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ready && !init) |=> $stable(way_ages));

  p_bad_way_r8: assert property (@(posedge clk) disable iff (rst)
    (touch_vld && !init && 32'(touch_way) >= NUM_WAYS) |=> $stable(way_ages));
endmodule

bind lru_age_tracker lru_age_chk #(
  .NUM_WAYS(NUM_WAYS),
  .IDX_W   (IDX_W),
  .AGE_W   (AGE_W)
) chk_i (.*);

// File: tb/lru_age_tracker_tb.sv
module lru_age_tracker_tb_top;
  localparam int CLK_P = 10;
  localparam int NW    = 3;
  localparam int AW    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          init = 1'b0;
  logic          touch_vld = 1'b0;
  logic [1:0]    touch_way = '0;
  logic          ready;
  logic [1:0]    victim_way;
  logic [NW*AW-1:0] way_ages;

  int checks = 0;
  int fails  = 0;
  int ord [NW];     // ord[0] is the most recent way
  bit primed_m = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lru_age_tracker #(.NUM_WAYS(NW)) dut_i (
    .clk(clk), .rst(rst), .init(init), .touch_vld(touch_vld),
    .touch_way(touch_way), .ready(ready), .victim_way(victim_way),
    .way_ages(way_ages)
  );

  function automatic int age_of(int w);
    if (!primed_m) return 0;
    for (int p = 0; p < NW; p++) if (ord[p] == w) return p;
    return 0;
  endfunction

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [NW*AW-1:0] exp_ages;
    for (int w = 0; w < NW; w++) exp_ages[w*AW +: AW] = AW'(age_of(w));
    expect_eq(tag, "ready", int'(ready), int'(primed_m));
    expect_eq(tag, "ages", int'(way_ages), int'(exp_ages));
    expect_eq("R6", "victim", int'(victim_way), primed_m ? ord[NW-1] : 0);
    if (ready) begin
      int seen = 0;
      for (int w = 0; w < NW; w++) seen |= 1 << way_ages[w*AW +: AW];
      expect_eq("R5", "age permutation mask", seen, (1 << NW) - 1);
    end
  endtask

  task automatic step(bit i, bit v, int w, string tag);
    init = i; touch_vld = v; touch_way = 2'(w);
    @(posedge clk);
    if (i) begin
      for (int p = 0; p < NW; p++) ord[p] = p;
      primed_m = 1'b1;
    end else if (v && primed_m && w < NW) begin
      int pos = 0;
      for (int p = 0; p < NW; p++) if (ord[p] == w) pos = p;
      for (int p = pos; p > 0; p--) ord[p] = ord[p-1];
      ord[0] = w;
    end
    @(negedge clk);
    init = 1'b0; touch_vld = 1'b0; touch_way = '0;
    compare(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < NW; p++) ord[p] = p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1");

    step(0, 1, 1, "R3");          // touch before priming
    step(0, 1, 2, "R3");
    step(1, 0, 0, "R2");          // prime
    step(0, 1, 0, "R9");          // youngest way touched
    step(0, 1, 2, "R4");          // oldest way touched
    step(0, 1, 1, "R4");
    step(0, 1, 3, "R8");          // invalid index
    step(0, 0, 0, "R11");
    step(0, 0, 0, "R11");
    step(1, 1, 2, "R7");          // prime and touch together
    step(0, 1, 2, "R4");
    step(0, 1, 1, "R4");
    step(1, 0, 0, "R10");         // re-prime from scrambled order

    for (int n = 0; n < 500; n++) begin
      int r = int'($urandom_range(0, 19));
      int w = int'($urandom_range(0, 3));
      if (r == 0) step(1, 0, 0, "R10");
      else if (r == 1) step(1, 1, w, "R7");
      else if (r < 5) step(0, 0, 0, "R11");
      else step(0, 1, w, (w == 3) ? "R8" : "R4");
    end

    rst = 1'b1;
    @(posedge clk);
    primed_m = 1'b0;
    for (int p = 0; p < NW; p++) ord[p] = p;
    @(negedge clk);
    rst = 1'b0;
    compare("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule